// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block feeds the add-compare-select stage of a Viterbi decoder that takes three soft-decision values for each trellis step. The received values arrive one per cycle on a narrow 3-bit port. A serial-to-parallel front end collects them, and a bank of signed adders then forms one correlation metric for each of the eight possible 3-bit code labels.

Each soft value is a two's-complement number from -3 to +3. The metric for a label is the sum of the three values. Each value is added or subtracted according to one bit of the label. All eight metrics are registered and presented together on a packed bus, with a one-cycle valid pulse. The metrics stay on the bus until the next set replaces them, so the downstream stage may read them at any time after the pulse.

Top module: `soft_bmu`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `metricValid` is 0 and every metric on `metricBus` is 0. The first accepted sample after reset is taken as the first value of a set.
- R2: A sample is accepted only in a cycle with `sampleValid` high. Accepted samples are assigned in turn to the first value (s0), the second value (s1) and the third value (s2), and then the order repeats. Cycles with `sampleValid` low do not advance this position, so idle gaps may appear anywhere in a set.
- R3: `metricValid` is high for exactly one cycle. That cycle follows the clock edge that accepts the third sample of a set. The flag is never high in two consecutive cycles.
- R4: The metric for label k (k = 0..7) sits at `metricBus[8*k+7 : 8*k]`. Write k as bits b2 b1 b0. A 1 in b2 subtracts s0 instead of adding it, a 1 in b1 does the same for s1, and a 1 in b0 does the same for s2.
- R5: When all three samples are +3, the metrics for labels 0 through 7 are 9, 3, 3, -3, 3, -3, -3, -9.
- R6: An input code of 3'b100 (-4) is treated as -3. As a result, every metric lies between -9 and +9.
- R7: Between valid pulses, `metricBus` holds its last value unchanged.
- R8: For each label k, the metrics for label k and label 7-k sum to zero.
- R9: Every metric is an 8-bit two's-complement value that is correctly sign-extended. For example, -9 appears as 8'hF7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies `sampleIn` for the current cycle |
| sampleIn | input | 3 | Soft sample, two's complement |
| metricValid | output | 1 | One-cycle pulse: a new set of metrics is on the bus |
| metricBus | output | 64 | Eight 8-bit signed metrics, label k in byte k |

## Verification
Only one result timing exists: a metric set and its valid pulse appear one register stage after the edge that accepts the third sample. The bench drives inputs on falling edges and samples 1 ns after the rising edge that captures the third sample. It then checks the flag low and the bus unchanged one cycle later. Random idle gaps are inserted between samples to show that the set position moves only on accepted samples, so the pulse lands exactly at the accepted third sample regardless of gaps.

// File: rtl/soft_bmu_pkg.sv
package soft_bmu_pkg;
  localparam int SAMPLE_W  = 3;
  localparam int METRIC_W  = 8;
  localparam int NUM_IN    = 3;
  localparam int NUM_LABEL = 1 << NUM_IN;
  localparam int SLOT_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_IN-1:0] load;  // capture sample into slot j
    logic              fire;  // last slot arrived: compute and register metrics
  } bmuStrobe_t;
endpackage

// File: rtl/soft_bmu_ctrl.sv
module soft_bmu_ctrl
  import soft_bmu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  output bmuStrobe_t strobe
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_IN - 1);

  logic [SLOT_W-1:0] slotQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
    end else if (sampleValid) begin
      if (slotQ == LAST_SLOT) slotQ <= '0;
      else                    slotQ <= slotQ + 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    for (int j = 0; j < NUM_IN; j++) begin
      strobe.load[j] = sampleValid && (slotQ == SLOT_W'(j));
    end
    strobe.fire = sampleValid && (slotQ == LAST_SLOT);
  end
endmodule

// File: rtl/soft_bmu_dp.sv
module soft_bmu_dp
  import soft_bmu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  bmuStrobe_t                    strobe,
  input  logic [SAMPLE_W-1:0]           sampleIn,
  output logic                          metricValid,
  output logic [NUM_LABEL*METRIC_W-1:0] metricBus
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] SAT_NEG  = MOST_NEG + 1'b1;

  logic [SAMPLE_W-1:0]        satSample;
  logic [SAMPLE_W-1:0]        heldQ  [NUM_IN-1];
  logic signed [METRIC_W-1:0] opnd   [NUM_IN];
  logic signed [METRIC_W-1:0] sumD   [NUM_LABEL];
  logic signed [METRIC_W-1:0] metricQ[NUM_LABEL];

  // Clamp the asymmetric code so the range is symmetric
  assign satSample = (sampleIn == MOST_NEG) ? SAT_NEG : sampleIn;

  // Serial-to-parallel: all but the last slot are stored, the last is live
  for (genvar j = 0; j < NUM_IN; j++) begin : g_slot
    if (j < NUM_IN - 1) begin : g_held
      always_ff @(posedge clk) begin
        if (!rstN)              heldQ[j] <= '0;
        else if (strobe.load[j]) heldQ[j] <= satSample;
      end
      assign opnd[j] = {{(METRIC_W-SAMPLE_W){heldQ[j][SAMPLE_W-1]}}, heldQ[j]};
    end else begin : g_live
      assign opnd[j] = {{(METRIC_W-SAMPLE_W){satSample[SAMPLE_W-1]}}, satSample};
    end
  end

  // One signed adder chain per label; label MSB steers the first sample
  for (genvar k = 0; k < NUM_LABEL; k++) begin : g_label
    localparam logic [NUM_IN-1:0] LBL = NUM_IN'(k);
    always_comb begin
      sumD[k] = '0;
      for (int j = 0; j < NUM_IN; j++) begin
        if (LBL[NUM_IN-1-j]) sumD[k] = sumD[k] - opnd[j];
        else                 sumD[k] = sumD[k] + opnd[j];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)            metricQ[k] <= '0;
      else if (strobe.fire) metricQ[k] <= sumD[k];
    end

    assign metricBus[k*METRIC_W +: METRIC_W] = metricQ[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) metricValid <= 1'b0;
    else       metricValid <= strobe.fire;
  end
endmodule

// File: rtl/soft_bmu.sv
module soft_bmu
  import soft_bmu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sampleValid,
  input  logic [SAMPLE_W-1:0]           sampleIn,
  output logic                          metricValid,
  output logic [NUM_LABEL*METRIC_W-1:0] metricBus
);
  bmuStrobe_t strobe;

  soft_bmu_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .strobe      (strobe)
  );

  soft_bmu_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleIn    (sampleIn),
    .metricValid (metricValid),
    .metricBus   (metricBus)
  );
endmodule

// File: rtl/soft_bmu_chk.sv
module soft_bmu_chk
  import soft_bmu_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          sampleValid,
  input logic [SAMPLE_W-1:0]           sampleIn,
  input logic                          metricValid,
  input logic [NUM_LABEL*METRIC_W-1:0] metricBus
);
  localparam int MAX_MAG = NUM_IN * ((1 << (SAMPLE_W-1)) - 1);

  // Independent count of accepted samples
  logic [SLOT_W-1:0] seenQ;
  always_ff @(posedge clk) begin
    if (!rstN) seenQ <= '0;
    else if (sampleValid) seenQ <= (seenQ == SLOT_W'(NUM_IN-1)) ? '0 : seenQ + 1'b1;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    metricValid |=> !metricValid); // R3

  AST_FIRE_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && seenQ == SLOT_W'(NUM_IN-1)) |=> metricValid); // R2

  AST_NO_EARLY_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && seenQ == SLOT_W'(NUM_IN-1)) |=> !metricValid); // R3

  AST_HOLD_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !metricValid |-> $stable(metricBus)); // R7

  for (genvar k = 0; k < NUM_LABEL; k++) begin : g_chk
    logic signed [METRIC_W-1:0] mK, mMirror;
    assign mK      = metricBus[k*METRIC_W +: METRIC_W];
    assign mMirror = metricBus[(NUM_LABEL-1-k)*METRIC_W +: METRIC_W];

    AST_MIRROR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      metricValid |-> (mK + mMirror == '0)); // R8

    AST_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      metricValid |-> ((int'(mK) <= MAX_MAG) && (int'(mK) >= -MAX_MAG))); // R6
  end
endmodule

bind soft_bmu soft_bmu_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleIn    (sampleIn),
  .metricValid (metricValid),
  .metricBus   (metricBus)
);

// File: tb/soft_bmu_bench.sv
`timescale 1ns/1ps
module soft_bmu_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [2:0]  sampleIn = '0;
  logic        metricValid;
  logic [63:0] metricBus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  soft_bmu u_soft_bmu (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleIn(sampleIn), .metricValid(metricValid), .metricBus(metricBus)
  );

  function automatic int satVal(input logic [2:0] s);
    int v;
    v = $signed(s);
    if (v < -3) v = -3;
    return v;
  endfunction

  function automatic int expMetric(input int lbl, input logic [2:0] a,
                                   input logic [2:0] b, input logic [2:0] c);
    int r;
    r  = lbl[2] ? -satVal(a) : satVal(a);
    r += lbl[1] ? -satVal(b) : satVal(b);
    r += lbl[0] ? -satVal(c) : satVal(c);
    return r;
  endfunction

  function automatic int busMetric(input int lbl);
    logic signed [7:0] m;
    m = metricBus[lbl*8 +: 8];
    return int'(m);
  endfunction

  task automatic checkInt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushSample(input logic [2:0] s, input int idle);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk); sampleValid = 1'b0;
    end
    @(negedge clk); sampleValid = 1'b1; sampleIn = s;
  endtask

  // Sends one set; checks pulse after the third accepted edge, then hold
  task automatic runSet(input logic [2:0] a, input logic [2:0] b,
                        input logic [2:0] c, input int maxIdle, input string tag);
    logic [63:0] snap;
    pushSample(a, (maxIdle > 0) ? int'($urandom_range(maxIdle)) : 0);
    pushSample(b, (maxIdle > 0) ? int'($urandom_range(maxIdle)) : 0);
    pushSample(c, (maxIdle > 0) ? int'($urandom_range(maxIdle)) : 0);
    @(posedge clk); #1;
    checkInt({tag, " R3 valid pulse"}, int'(metricValid), 1);
    for (int k = 0; k < 8; k++) begin
      checkInt({tag, " R4 metric"}, busMetric(k), expMetric(k, a, b, c));
    end
    checkInt({tag, " R8 mirror"}, busMetric(2) + busMetric(5), 0);
    snap = metricBus;
    @(negedge clk); sampleValid = 1'b0;
    @(posedge clk); #1;
    checkInt({tag, " R3 pulse ends"}, int'(metricValid), 0);
    checkInt({tag, " R7 hold"}, int'(metricBus == snap), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0b3c));
    repeat (3) @(posedge clk);
    #1;
    checkInt("R1 reset valid", int'(metricValid), 0);
    checkInt("R1 reset bus", int'(metricBus == 64'd0), 1);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkInt("R1 after release", int'(metricValid), 0);

    // R5: all +3
    runSet(3'b011, 3'b011, 3'b011, 0, "R5");
    checkInt("R5 label0", busMetric(0), 9);
    checkInt("R5 label3", busMetric(3), -3);
    checkInt("R5 label7", busMetric(7), -9);
    checkInt("R9 sign-extended -9", int'(metricBus[63:56]), 32'hF7);
    checkInt("R9 +9 byte", int'(metricBus[7:0]), 32'h09);

    // R6: -4 treated as -3
    runSet(3'b100, 3'b100, 3'b100, 0, "R6");
    checkInt("R6 saturated label0", busMetric(0), -9);
    checkInt("R6 saturated label7", busMetric(7), 9);
    runSet(3'b100, 3'b011, 3'b000, 1, "R6mix");

    // R4: single nonzero positions show which bit steers which sample
    runSet(3'b001, 3'b000, 3'b000, 0, "R4s0");
    checkInt("R4 b2 steers s0", busMetric(4), -1);
    runSet(3'b000, 3'b001, 3'b000, 0, "R4s1");
    checkInt("R4 b1 steers s1", busMetric(2), -1);
    runSet(3'b000, 3'b000, 3'b001, 0, "R4s2");
    checkInt("R4 b0 steers s2", busMetric(1), -1);

    // R2: long idle gaps inside a set; flag must stay low during them
    pushSample(3'b010, 0);
    pushSample(3'b111, 3);
    @(negedge clk); sampleValid = 1'b0;
    repeat (4) begin
      @(posedge clk); #1;
      checkInt("R2 no pulse mid-set", int'(metricValid), 0);
    end
    pushSample(3'b101, 0);
    @(posedge clk); #1;
    checkInt("R2 pulse after third", int'(metricValid), 1);
    checkInt("R2 ordered metric", busMetric(6), expMetric(6, 3'b010, 3'b111, 3'b101));
    @(negedge clk); sampleValid = 1'b0;

    // Random sets with random gaps
    for (int n = 0; n < 200; n++) begin
      runSet(3'($urandom_range(7)), 3'($urandom_range(7)), 3'($urandom_range(7)),
             2, "R4rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule